// File: doc/BRIEF.md
# Decaying Open-Bus Data Latch

This block holds the last value seen on the data lines of a register port whose unused read bits are left floating. Every register write loads the whole byte into an internal latch. Every read returns a byte in which the bits the selected register really drives come from the register, and the remaining positions come from the latch. The driven bits of a read are then stored back into the latch, while the undriven bits are left alone.

Each latch bit has its own age counter. The counter counts frame ticks since that bit was last refreshed. A stored one that goes more than `DECAY_FRAMES` ticks without a refresh fades to zero. Every counter stops just above the threshold, so it never wraps.

Each bit is a two-state machine:
- `CELL_EMPTY` means the stored value is zero.
- `CELL_HELD` means the stored value is one and is ageing.

The transitions are:
- `LOAD_ONE`: a refresh with value 1 goes to `CELL_HELD`.
- `LOAD_ZERO`: a refresh with value 0 goes to `CELL_EMPTY`.
- `EXPIRE`: a tick while the age equals the threshold moves `CELL_HELD` to `CELL_EMPTY`.
- `AGE`: any other tick stays in the same state and counts up.

The owning register decoder supplies three things: the write strobe, a flag that marks a write to the DMA-start address, and the read kind. Frame timing is generated elsewhere and arrives as a one-cycle tick.

Top module: `fading_bus_latch`

## Requirements
- R1: While and after reset (`rst_n` low), the latch and every age counter are zero, and `rd_q` is 0x00.
- R2: A write with `wr_en`=1 and `wr_is_dma`=0 loads all 8 latch bits from `wr_data` and restarts every bit's age at zero.
- R3: A write with `wr_is_dma`=1 leaves the latch and the ages unchanged.
- R4: A read (`rd_en`=1) updates `rd_q` at the next clock edge. The new value is (`rd_drive` AND mask) OR (latch AND NOT mask), where the latch value is the one held before this access. `rd_q` holds its value in cycles without a read.
- R5: The mask is chosen by `rd_kind`:
  - 0 means all bits are driven (0xFF).
  - 1 is a status read and drives bits 7:5 (0xE0).
  - 2 is a palette read and drives bits 5:0 (0x3F).
  - 3 takes the mask from `rd_mask`.
- R6: A read refreshes only the driven bits: they take `rd_drive` and restart their age. The undriven bits keep their value and age.
- R7: A bit holding 1 that is not refreshed is still 1 after 30 frame ticks and is 0 after the 31st.
- R8: Ages saturate at 31 and never wrap. A bit that decayed stays 0 through any number of further ticks, and after a new refresh it decays again after exactly 31 ticks.
- R9: When a refresh and the tick that would expire a bit fall in the same cycle, the refresh wins and the age restarts at zero.
- R10: When a full write and a read fall in the same cycle, the latch takes the write value. The read output is still formed from the latch as it was before the access.
- R11: Bits age independently: bits refreshed at different times expire on different ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| wr_en | input | 1 | Register write strobe |
| wr_is_dma | input | 1 | The write targets the DMA-start address |
| wr_data | input | DATA_W | Written byte |
| rd_en | input | 1 | Register read strobe |
| rd_kind | input | 2 | Read kind: 0 full, 1 status, 2 palette, 3 custom |
| rd_mask | input | DATA_W | Driven-bit mask used when rd_kind is 3 |
| rd_drive | input | DATA_W | Value driven by the selected register |
| rd_q | output | DATA_W | Merged read byte, registered |

## Verification
The contested cycle is a refresh landing on the same edge as the frame tick that would expire a bit. The bench first lets a fully written byte age for exactly 30 ticks. It then issues a new write together with the 31st tick, and peeks the latch through a custom read with an empty mask. The write value must survive that tick and must still be present 30 ticks later; it must vanish only on the tick after that. A second collision, a write and a partial read on one edge, is judged by checking that `rd_q` shows the old latch and that the next peek shows the written byte.

// File: rtl/fbl_pkg.sv
package fbl_pkg;

    typedef enum logic [1:0] {
        KIND_FULL    = 2'd0,
        KIND_STATUS  = 2'd1,
        KIND_PALETTE = 2'd2,
        KIND_CUSTOM  = 2'd3
    } rd_kind_e;

    typedef enum logic {
        CELL_EMPTY = 1'b0,
        CELL_HELD  = 1'b1
    } cell_state_e;

endpackage

// File: rtl/fbl_drive_mask.sv
module fbl_drive_mask
    import fbl_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter logic [DATA_W-1:0] STATUS_MASK  = 8'hE0,
    parameter logic [DATA_W-1:0] PALETTE_MASK = 8'h3F
) (
    input  logic [1:0]        kind,
    input  logic [DATA_W-1:0] custom_mask,
    output logic [DATA_W-1:0] drive_mask
);
    rd_kind_e kind_e;
    assign kind_e = rd_kind_e'(kind);

    always_comb begin
        unique case (kind_e)
            KIND_FULL:    drive_mask = '1;
            KIND_STATUS:  drive_mask = STATUS_MASK;
            KIND_PALETTE: drive_mask = PALETTE_MASK;
            KIND_CUSTOM:  drive_mask = custom_mask;
            default:      drive_mask = '1;
        endcase
    end
endmodule

// File: rtl/fbl_bit_cell.sv
module fbl_bit_cell
    import fbl_pkg::*;
#(
    parameter int DECAY_FRAMES = 30,
    parameter int AGE_W        = $clog2(DECAY_FRAMES + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             load_val,
    output logic             bit_q,
    output logic [AGE_W-1:0] age_q
);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(DECAY_FRAMES);
    localparam logic [AGE_W-1:0] AGE_CAP  = AGE_W'(DECAY_FRAMES + 1);

    cell_state_e state_q, state_d;
    logic [AGE_W-1:0] age_d;

    // next-state: LOAD_ONE, LOAD_ZERO, EXPIRE, AGE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_EMPTY: begin
                if (load && load_val) state_d = CELL_HELD;       // LOAD_ONE
            end
            CELL_HELD: begin
                if (load)                            state_d = load_val ? CELL_HELD : CELL_EMPTY;
                else if (tick && age_q == AGE_LAST)  state_d = CELL_EMPTY; // EXPIRE
            end
            default: state_d = CELL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CELL_EMPTY;
        else        state_q <= state_d;
    end

    // age counter: restarts on refresh, saturates at AGE_CAP (R8)
    always_comb begin
        age_d = age_q;
        if (load)                       age_d = '0;
        else if (tick && age_q < AGE_CAP) age_d = age_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    assign bit_q = (state_q == CELL_HELD);
endmodule

// File: rtl/fbl_read_port.sv
module fbl_read_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] drive_mask,
    input  logic [DATA_W-1:0] drive_val,
    input  logic [DATA_W-1:0] latch_val,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] merged;
    assign merged = (drive_val & drive_mask) | (latch_val & ~drive_mask);

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= merged;
    end
endmodule

// File: rtl/fading_bus_latch.sv
module fading_bus_latch
    import fbl_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter int                DECAY_FRAMES = 30,
    parameter logic [DATA_W-1:0] STATUS_MASK  = 8'hE0,
    parameter logic [DATA_W-1:0] PALETTE_MASK = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              wr_en,
    input  logic              wr_is_dma,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_kind,
    input  logic [DATA_W-1:0] rd_mask,
    input  logic [DATA_W-1:0] rd_drive,
    output logic [DATA_W-1:0] rd_q
);
    localparam int AGE_W = $clog2(DECAY_FRAMES + 2);

    logic [DATA_W-1:0]       drive_mask;
    logic [DATA_W-1:0]       held_bits;
    logic [DATA_W-1:0]       load_mask;
    logic [DATA_W-1:0]       load_data;
    logic [DATA_W*AGE_W-1:0] age_flat;
    logic                    full_wr;

    fbl_drive_mask #(
        .DATA_W      (DATA_W),
        .STATUS_MASK (STATUS_MASK),
        .PALETTE_MASK(PALETTE_MASK)
    ) mask_i (
        .kind       (rd_kind),
        .custom_mask(rd_mask),
        .drive_mask (drive_mask)
    );

    // a full write outranks the partial refresh of a same-cycle read
    assign full_wr   = wr_en && !wr_is_dma;
    assign load_mask = full_wr ? '1 : (rd_en ? drive_mask : '0);
    assign load_data = full_wr ? wr_data : rd_drive;

    for (genvar b = 0; b < DATA_W; b++) begin : g_cell
        fbl_bit_cell #(
            .DECAY_FRAMES(DECAY_FRAMES),
            .AGE_W       (AGE_W)
        ) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (frame_tick),
            .load    (load_mask[b]),
            .load_val(load_data[b]),
            .bit_q   (held_bits[b]),
            .age_q   (age_flat[b*AGE_W +: AGE_W])
        );
    end

    fbl_read_port #(.DATA_W(DATA_W)) port_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .drive_mask(drive_mask),
        .drive_val (rd_drive),
        .latch_val (held_bits),
        .rd_q      (rd_q)
    );
endmodule

// File: rtl/fbl_checker.sv
module fbl_checker #(
    parameter int                DATA_W       = 8,
    parameter int                DECAY_FRAMES = 30,
    parameter int                AGE_W        = 5,
    parameter logic [DATA_W-1:0] STATUS_MASK  = 8'hE0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_tick,
    input logic                    wr_en,
    input logic                    wr_is_dma,
    input logic [DATA_W-1:0]       wr_data,
    input logic                    rd_en,
    input logic [1:0]              rd_kind,
    input logic [DATA_W-1:0]       rd_drive,
    input logic [DATA_W-1:0]       rd_q,
    input logic [DATA_W-1:0]       held_bits,
    input logic [DATA_W*AGE_W-1:0] age_flat
);
    assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_is_dma) |=> (held_bits == $past(wr_data)));

    assert_dma_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_is_dma && !rd_en && !frame_tick) |=> $stable(held_bits));

    assert_hold_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q));

    assert_status_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_kind == 2'd1) |=>
        ((rd_q & ~STATUS_MASK) == ($past(held_bits) & ~STATUS_MASK)) &&
        ((rd_q & STATUS_MASK) == ($past(rd_drive) & STATUS_MASK)));

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assert_age_capped_R8: assert property (@(posedge clk) disable iff (!rst_n)
            age_flat[b*AGE_W +: AGE_W] <= AGE_W'(DECAY_FRAMES + 1));

        assert_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(held_bits[b]) |-> $past(frame_tick || wr_en || rd_en));

        assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(held_bits[b]) |-> $past(wr_en || rd_en));
    end
endmodule

bind fading_bus_latch fbl_checker #(
    .DATA_W      (DATA_W),
    .DECAY_FRAMES(DECAY_FRAMES),
    .AGE_W       (AGE_W),
    .STATUS_MASK (STATUS_MASK)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_tick(frame_tick),
    .wr_en     (wr_en),
    .wr_is_dma (wr_is_dma),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_kind   (rd_kind),
    .rd_drive  (rd_drive),
    .rd_q      (rd_q),
    .held_bits (held_bits),
    .age_flat  (age_flat)
);

// File: tb/fading_bus_latch_tb.sv
`timescale 1ns/1ps
module fading_bus_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_is_dma = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_kind = '0;
    logic [7:0] rd_mask = '0;
    logic [7:0] rd_drive = '0;
    logic [7:0] rd_q;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fading_bus_latch dut_i (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .wr_en(wr_en), .wr_is_dma(wr_is_dma), .wr_data(wr_data),
        .rd_en(rd_en), .rd_kind(rd_kind), .rd_mask(rd_mask),
        .rd_drive(rd_drive), .rd_q(rd_q)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic idle_cycle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_write(logic [7:0] d, bit dma);
        wr_en = 1'b1; wr_is_dma = dma; wr_data = d;
        idle_cycle();
        wr_en = 1'b0; wr_is_dma = 1'b0;
    endtask

    task automatic do_read(logic [1:0] k, logic [7:0] m, logic [7:0] d);
        rd_en = 1'b1; rd_kind = k; rd_mask = m; rd_drive = d;
        idle_cycle();
        rd_en = 1'b0;
    endtask

    // custom read with an empty mask returns the latch and refreshes nothing
    task automatic peek(output logic [7:0] v);
        do_read(2'd3, 8'h00, 8'h00);
        v = rd_q;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            frame_tick = 1'b1; idle_cycle(); frame_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 rd_q after reset", rd_q, 8'h00);
        peek(v);
        check("R1 latch after reset", v, 8'h00);
    endtask

    task automatic t_write_dma();
        logic [7:0] v;
        do_write(8'hA5, 1'b0);
        peek(v);
        check("R2 full write", v, 8'hA5);
        do_write(8'h3C, 1'b1);
        check("R4 rd_q held without read", rd_q, 8'hA5);
        peek(v);
        check("R3 dma write ignored", v, 8'hA5);
    endtask

    task automatic t_read_kinds();
        logic [7:0] v;
        do_read(2'd1, 8'h00, 8'h40);
        check("R4 R5 status merge", rd_q, 8'h45);
        peek(v);
        check("R6 status refresh", v, 8'h45);
        do_read(2'd2, 8'h00, 8'h2A);
        check("R5 palette merge", rd_q, 8'h6A);
        do_read(2'd0, 8'h00, 8'h81);
        check("R5 full read", rd_q, 8'h81);
        do_read(2'd3, 8'h0F, 8'hFF);
        check("R5 custom merge", rd_q, 8'h8F);
        peek(v);
        check("R6 custom refresh", v, 8'h8F);
    endtask

    task automatic t_decay();
        logic [7:0] v;
        do_write(8'hFF, 1'b0);
        ticks(30);
        peek(v);
        check("R7 held at 30 ticks", v, 8'hFF);
        ticks(1);
        peek(v);
        check("R7 cleared at 31st tick", v, 8'h00);
    endtask

    task automatic t_independent();
        logic [7:0] v;
        do_write(8'hFF, 1'b0);
        ticks(10);
        do_read(2'd3, 8'h0F, 8'h0F);
        ticks(20);
        peek(v);
        check("R11 all held", v, 8'hFF);
        ticks(1);
        peek(v);
        check("R11 high nibble expired", v, 8'h0F);
        ticks(9);
        peek(v);
        check("R11 low nibble still held", v, 8'h0F);
        ticks(1);
        peek(v);
        check("R11 low nibble expired", v, 8'h00);
    endtask

    task automatic t_refresh_vs_expire();
        logic [7:0] v;
        do_write(8'hFF, 1'b0);
        ticks(30);
        wr_en = 1'b1; wr_data = 8'hF0; frame_tick = 1'b1;
        idle_cycle();
        wr_en = 1'b0; frame_tick = 1'b0;
        peek(v);
        check("R9 refresh wins", v, 8'hF0);
        ticks(30);
        peek(v);
        check("R9 age restarted", v, 8'hF0);
        ticks(1);
        peek(v);
        check("R9 later expiry", v, 8'h00);
    endtask

    task automatic t_write_with_read();
        logic [7:0] v;
        do_write(8'h81, 1'b0);
        wr_en = 1'b1; wr_data = 8'h5A;
        rd_en = 1'b1; rd_kind = 2'd3; rd_mask = 8'h0F; rd_drive = 8'h0F;
        idle_cycle();
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 read uses old latch", rd_q, 8'h8F);
        peek(v);
        check("R10 write wins latch", v, 8'h5A);
    endtask

    task automatic t_saturate();
        logic [7:0] v;
        do_write(8'hFF, 1'b0);
        ticks(70);
        peek(v);
        check("R8 stays clear after long idle", v, 8'h00);
        do_write(8'h01, 1'b0);
        ticks(30);
        peek(v);
        check("R8 rewrite held", v, 8'h01);
        ticks(1);
        peek(v);
        check("R8 rewrite expires", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_dma();
        t_read_kinds();
        t_decay();
        t_independent();
        t_refresh_vs_expire();
        t_write_with_read();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule